// File: doc/BRIEF.md
# Safety State Supervisor

This block sits at the end of a set of safety monitors. Each monitor hands it a single-bit raw fault flag, and the block moves the device through five operating states. Those states are idle, initial checking, normal operation, fault and disabled. Every flag belongs to one of three recovery classes. A supply or thermal flag holds the device in the fault state until the flag is gone. A signal-path flag passes through the fault state for one cycle and then retries the initial checks at once. An integrity flag sends the device to the disabled state, where it waits for a fixed time before it retries the initial checks.

Supply and signal-path flags are filtered by de-glitch counters, and each class has its own programmable limit. Three configuration strap pins are captured while the initial checks run. They are compared with that capture during normal operation. A change on either test strap disables the device at once. A change on the gain-select strap disables it only after its own de-glitch limit. The outputs are the encoded state, an output-enable signal and a sticky cause code that names the fault behind the latest exit from normal operation.

Top module: `diag_supervisor`

## Requirements
- R1: While reset is asserted, and after it, the state is idle (code 0), the output enable is low and the cause code is 0x00. State codes are: 0 idle, 1 checking, 2 normal, 3 fault, 4 disabled.
- R2: The block leaves idle for checking on the edge where start is high. It leaves checking for normal on an edge where init_ok is high. Output enable is high in checking and normal, and low in all other states.
- R3: If init_ok is never seen, checking ends after DIAG_TMO cycles with a move to the fault state. The next edge goes back to checking. This exit does not change the cause code.
- R4: A supply or signal-path flag is acted on only after it has been high at LIM+1 consecutive edges in normal operation, where LIM is the class limit. A pulse that is high for LIM edges or fewer has no effect.
- R5: A qualified supply flag moves normal to fault. Fault is held while any enabled supply flag is high, and the edge after they all drop goes to checking.
- R6: Supply flag bit 1 (the undervoltage bit) is ignored unless mode_5v_i is high.
- R7: A qualified signal-path flag moves normal to fault. The next edge goes to checking even when the flag is still high.
- R8: Signal-path bit 4 is the output-short flag. While its de-glitch count runs, the output enable stays high.
- R9: In normal operation, crc_bad_i or copy_bad_i moves the device to disabled on the next edge, with no de-glitch. Outside normal operation these flags are ignored.
- R10: The straps are captured in checking and compared in normal operation. A change on bit 0 or bit 1 disables the device on the next edge. A change on bit 2 disables it after the gain limit, with the same counting as R4.
- R11: Disabled lasts DIS_HOLD cycles and then moves to checking.
- R12: On each exit from normal operation, the cause code is written as class in [7:6] and index in [5:0]. The classes are 1 supply, 2 signal, 3 integrity. Integrity has priority over supply, and supply over signal; within a class the lowest index wins. The integrity indices are 0 crc, 1 copy, and 2 to 4 for strap bits 0 to 2. The cause code holds between exits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Leave idle and begin the initial checks |
| init_ok_i | input | 1 | All initial checks have passed |
| mode_5v_i | input | 1 | 5 V supply mode; enables the undervoltage flag |
| supply_flt_i | input | 4 | Raw supply/thermal flags: 0 VCC over, 1 VCC under, 2 regulator over, 3 over-temperature |
| sig_flt_i | input | SIG_N | Raw signal-path flags (bit 4 is output short) |
| crc_bad_i | input | 1 | Register CRC mismatch |
| copy_bad_i | input | 1 | Mismatch against the redundant register copy |
| cfg_pins_i | input | 3 | Straps: 0 test mode, 1 test output, 2 gain select |
| lim_sup_i | input | CW | De-glitch limit for supply flags |
| lim_sig_i | input | CW | De-glitch limit for signal-path flags |
| lim_gain_i | input | CW | De-glitch limit for a gain-strap change |
| state_o | output | 3 | Encoded current state |
| out_en_o | output | 1 | Output stage enable |
| cause_o | output | 8 | Sticky fault cause code |

## Verification
The assertions assume that the raw flags are synchronous to the clock and already have their analog hysteresis applied. They also assume that the limit inputs only change while no matching flag is counting. The stimulus changes every input half a cycle away from the active edge. It changes limits only when all flags are low. It keeps init_ok high after the first timeout, so that every retry passes through checking in one cycle, and it holds every strap steady during checking.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DIAG  = 3'd1,
        ST_NORM  = 3'd2,
        ST_FAULT = 3'd3,
        ST_DIS   = 3'd4
    } sup_state_e;

    typedef enum logic [1:0] {
        CL_NONE    = 2'd0,
        CL_SUPPLY  = 2'd1,
        CL_SIGNAL  = 2'd2,
        CL_DISABLE = 2'd3
    } flt_class_e;

    typedef struct packed {
        flt_class_e  cls;
        logic [5:0]  idx;
    } cause_t;

    localparam int SUP_N    = 4;
    localparam int UV_BIT   = 1;
    localparam int PIN_N    = 3;
    localparam int DIS_CRC  = 0;
    localparam int DIS_COPY = 1;
    localparam int DIS_PIN0 = 2;
    localparam int DIS_N    = DIS_PIN0 + PIN_N;

    function automatic logic [5:0] lowest_set(input logic [63:0] v);
        logic [5:0] r;
        r = '0;
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) r = 6'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/sup_deglitch.sv
module sup_deglitch #(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    input  logic          raw_i,
    input  logic [CW-1:0] lim_i,
    output logic          qual_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_q;
    logic          live;

    assign live = en_i & raw_i;

    always_ff @(posedge clk_i) begin
        if (rst_i || !live) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign qual_o = live & (cnt_q >= lim_i);

    logic past_ok_q;
    always_ff @(posedge clk_i) begin
        if (rst_i) past_ok_q <= 1'b0;
        else       past_ok_q <= 1'b1;
    end

    // R4
    first_edge_blocked_chk: assert property (@(posedge clk_i) disable iff (rst_i || !past_ok_q)
        (live && !$past(live) && lim_i != '0) |-> !qual_o);

endmodule

// File: rtl/sup_cfg_watch.sv
module sup_cfg_watch
    import sup_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             latch_i,
    input  logic             chk_i,
    input  logic [PIN_N-1:0] pins_i,
    input  logic [CW-1:0]    lim_i,
    output logic [PIN_N-1:0] chg_o
);
    localparam int GAIN_BIT = PIN_N - 1;

    logic [PIN_N-1:0] ref_q;
    logic [PIN_N-1:0] diff;

    always_ff @(posedge clk_i) begin
        if (rst_i)        ref_q <= '0;
        else if (latch_i) ref_q <= pins_i;
    end

    assign diff = (pins_i ^ ref_q) & {PIN_N{chk_i}};

    for (genvar g = 0; g < PIN_N; g++) begin : g_pin
        if (g == GAIN_BIT) begin : g_filt
            sup_deglitch #(.CW(CW)) dg_i (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .en_i   (chk_i),
                .raw_i  (diff[g]),
                .lim_i  (lim_i),
                .qual_o (chg_o[g])
            );
        end else begin : g_direct
            assign chg_o[g] = diff[g];
        end
    end

    logic past_ok_q;
    always_ff @(posedge clk_i) begin
        if (rst_i) past_ok_q <= 1'b0;
        else       past_ok_q <= 1'b1;
    end

    // R10
    ref_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i || !past_ok_q)
        !$past(latch_i) |-> $stable(ref_q));

    // R10
    no_change_outside_check_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !chk_i |-> (chg_o == '0));

endmodule

// File: rtl/sup_fault_collect.sv
module sup_fault_collect
    import sup_pkg::*;
#(
    parameter int SIG_N = 8,
    parameter int CW    = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             mode_5v_i,
    input  logic [SUP_N-1:0] sup_raw_i,
    input  logic [SIG_N-1:0] sig_raw_i,
    input  logic [DIS_N-1:0] dis_raw_i,
    input  logic [CW-1:0]    lim_sup_i,
    input  logic [CW-1:0]    lim_sig_i,
    output logic             dis_any_o,
    output logic             sup_any_o,
    output logic             sig_any_o,
    output logic             sup_clear_o,
    output cause_t           cause_o
);
    logic [SUP_N-1:0] sup_mask;
    logic [SUP_N-1:0] sup_q;
    logic [SIG_N-1:0] sig_q;
    logic [DIS_N-1:0] dis_q;

    always_comb begin
        sup_mask = sup_raw_i;
        sup_mask[UV_BIT] = sup_raw_i[UV_BIT] & mode_5v_i;
    end

    for (genvar s = 0; s < SUP_N; s++) begin : g_sup
        sup_deglitch #(.CW(CW)) dg_i (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .en_i   (en_i),
            .raw_i  (sup_mask[s]),
            .lim_i  (lim_sup_i),
            .qual_o (sup_q[s])
        );
    end

    for (genvar k = 0; k < SIG_N; k++) begin : g_sig
        sup_deglitch #(.CW(CW)) dg_i (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .en_i   (en_i),
            .raw_i  (sig_raw_i[k]),
            .lim_i  (lim_sig_i),
            .qual_o (sig_q[k])
        );
    end

    assign dis_q       = dis_raw_i & {DIS_N{en_i}};
    assign dis_any_o   = |dis_q;
    assign sup_any_o   = |sup_q;
    assign sig_any_o   = |sig_q;
    assign sup_clear_o = (sup_mask == '0);

    always_comb begin
        cause_o = '0;
        if (|dis_q) begin
            cause_o.cls = CL_DISABLE;
            cause_o.idx = lowest_set(64'(dis_q));
        end else if (|sup_q) begin
            cause_o.cls = CL_SUPPLY;
            cause_o.idx = lowest_set(64'(sup_q));
        end else if (|sig_q) begin
            cause_o.cls = CL_SIGNAL;
            cause_o.idx = lowest_set(64'(sig_q));
        end
    end

    // R6
    uv_masked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !mode_5v_i |-> !sup_q[UV_BIT]);

    // R9
    dis_gated_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |-> !(dis_any_o || sup_any_o || sig_any_o));

endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
    import sup_pkg::*;
#(
    parameter int DIAG_TMO = 16,
    parameter int DIS_HOLD = 8
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       start_i,
    input  logic       init_ok_i,
    input  logic       dis_any_i,
    input  logic       sup_any_i,
    input  logic       sig_any_i,
    input  logic       sup_clear_i,
    input  cause_t     cause_i,
    output sup_state_e state_o,
    output cause_t     cause_o
);
    localparam int TMAX = (DIAG_TMO > DIS_HOLD) ? DIAG_TMO : DIS_HOLD;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] DIAG_LAST = TW'(DIAG_TMO - 1);
    localparam logic [TW-1:0] DIS_LAST  = TW'(DIS_HOLD - 1);

    sup_state_e    state_q;
    logic [TW-1:0] tmr_q;
    logic          wait_clr_q;
    cause_t        cause_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= ST_IDLE;
            tmr_q      <= '0;
            wait_clr_q <= 1'b0;
            cause_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_DIAG;
                        tmr_q   <= '0;
                    end
                end
                ST_DIAG: begin
                    if (init_ok_i) begin
                        state_q <= ST_NORM;
                    end else if (tmr_q == DIAG_LAST) begin
                        state_q    <= ST_FAULT;
                        wait_clr_q <= 1'b0;
                        tmr_q      <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_NORM: begin
                    if (dis_any_i) begin
                        state_q <= ST_DIS;
                        tmr_q   <= '0;
                        cause_q <= cause_i;
                    end else if (sup_any_i) begin
                        state_q    <= ST_FAULT;
                        wait_clr_q <= 1'b1;
                        cause_q    <= cause_i;
                    end else if (sig_any_i) begin
                        state_q    <= ST_FAULT;
                        wait_clr_q <= 1'b0;
                        cause_q    <= cause_i;
                    end
                end
                ST_FAULT: begin
                    if (!wait_clr_q || sup_clear_i) begin
                        state_q <= ST_DIAG;
                        tmr_q   <= '0;
                    end
                end
                ST_DIS: begin
                    if (tmr_q == DIS_LAST) begin
                        state_q <= ST_DIAG;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign cause_o = cause_q;

    logic past_ok_q;
    always_ff @(posedge clk_i) begin
        if (rst_i) past_ok_q <= 1'b0;
        else       past_ok_q <= 1'b1;
    end

    // R2
    norm_needs_ok_chk: assert property (@(posedge clk_i) disable iff (rst_i || !past_ok_q)
        ($past(state_q) == ST_DIAG && state_q == ST_NORM) |-> $past(init_ok_i));

    // R3
    timeout_without_ok_chk: assert property (@(posedge clk_i) disable iff (rst_i || !past_ok_q)
        ($past(state_q) == ST_DIAG && state_q == ST_FAULT) |-> !$past(init_ok_i));

    // R5
    wait_until_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i || !past_ok_q)
        ($past(state_q) == ST_FAULT && $past(wait_clr_q) && state_q == ST_DIAG) |-> $past(sup_clear_i));

    // R7
    retry_at_once_chk: assert property (@(posedge clk_i) disable iff (rst_i || !past_ok_q)
        ($past(state_q) == ST_FAULT && !$past(wait_clr_q)) |-> state_q == ST_DIAG);

    // R9
    disable_has_source_chk: assert property (@(posedge clk_i) disable iff (rst_i || !past_ok_q)
        ($past(state_q) == ST_NORM && state_q == ST_DIS) |-> $past(dis_any_i));

    // R12
    cause_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i || !past_ok_q)
        ($past(state_q) != ST_NORM) |-> $stable(cause_q));

endmodule

// File: rtl/diag_supervisor.sv
module diag_supervisor
    import sup_pkg::*;
#(
    parameter int SIG_N    = 8,
    parameter int CW       = 8,
    parameter int DIAG_TMO = 16,
    parameter int DIS_HOLD = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic             init_ok_i,
    input  logic             mode_5v_i,
    input  logic [3:0]       supply_flt_i,
    input  logic [SIG_N-1:0] sig_flt_i,
    input  logic             crc_bad_i,
    input  logic             copy_bad_i,
    input  logic [2:0]       cfg_pins_i,
    input  logic [CW-1:0]    lim_sup_i,
    input  logic [CW-1:0]    lim_sig_i,
    input  logic [CW-1:0]    lim_gain_i,
    output logic [2:0]       state_o,
    output logic             out_en_o,
    output logic [7:0]       cause_o
);
    sup_state_e       state;
    cause_t           cause_now;
    cause_t           cause_reg;
    logic             in_norm;
    logic [PIN_N-1:0] pin_chg;
    logic [DIS_N-1:0] dis_raw;
    logic             dis_any, sup_any, sig_any, sup_clear;

    assign in_norm = (state == ST_NORM);

    sup_cfg_watch #(.CW(CW)) watch_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .latch_i (state == ST_DIAG),
        .chk_i   (in_norm),
        .pins_i  (cfg_pins_i),
        .lim_i   (lim_gain_i),
        .chg_o   (pin_chg)
    );

    always_comb begin
        dis_raw = '0;
        dis_raw[DIS_CRC]  = crc_bad_i;
        dis_raw[DIS_COPY] = copy_bad_i;
        dis_raw[DIS_PIN0 +: PIN_N] = pin_chg;
    end

    sup_fault_collect #(.SIG_N(SIG_N), .CW(CW)) collect_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .en_i        (in_norm),
        .mode_5v_i   (mode_5v_i),
        .sup_raw_i   (supply_flt_i),
        .sig_raw_i   (sig_flt_i),
        .dis_raw_i   (dis_raw),
        .lim_sup_i   (lim_sup_i),
        .lim_sig_i   (lim_sig_i),
        .dis_any_o   (dis_any),
        .sup_any_o   (sup_any),
        .sig_any_o   (sig_any),
        .sup_clear_o (sup_clear),
        .cause_o     (cause_now)
    );

    sup_fsm #(.DIAG_TMO(DIAG_TMO), .DIS_HOLD(DIS_HOLD)) fsm_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .start_i     (start_i),
        .init_ok_i   (init_ok_i),
        .dis_any_i   (dis_any),
        .sup_any_i   (sup_any),
        .sig_any_i   (sig_any),
        .sup_clear_i (sup_clear),
        .cause_i     (cause_now),
        .state_o     (state),
        .cause_o     (cause_reg)
    );

    assign state_o  = state;
    assign out_en_o = (state == ST_DIAG) || (state == ST_NORM);
    assign cause_o  = cause_reg;

    logic past_ok_q;
    always_ff @(posedge clk_i) begin
        if (rst_i) past_ok_q <= 1'b0;
        else       past_ok_q <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        $past(rst_i) |-> (state_o == 3'd0 && !out_en_o && cause_o == 8'h00));

    // R8
    short_filter_keeps_oe_chk: assert property (@(posedge clk_i) disable iff (rst_i || !past_ok_q)
        ($past(in_norm) && !$past(dis_any) && !$past(sup_any) && !$past(sig_any)) |-> out_en_o);

endmodule

// File: tb/diag_supervisor_tb_top.sv
module diag_supervisor_tb_top;

    localparam int SIG_N = 8;
    localparam int CW    = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             start, init_ok, mode_5v;
    logic [3:0]       sup;
    logic [SIG_N-1:0] sig;
    logic             crc, copy;
    logic [2:0]       pins;
    logic [CW-1:0]    lim_sup, lim_sig, lim_gain;
    logic [2:0]       state;
    logic             oe;
    logic [7:0]       cause;

    always #2 clk = ~clk;

    diag_supervisor #(.SIG_N(SIG_N), .CW(CW), .DIAG_TMO(16), .DIS_HOLD(8)) dut_i (
        .clk_i(clk), .rst_i(rst), .start_i(start), .init_ok_i(init_ok),
        .mode_5v_i(mode_5v), .supply_flt_i(sup), .sig_flt_i(sig),
        .crc_bad_i(crc), .copy_bad_i(copy), .cfg_pins_i(pins),
        .lim_sup_i(lim_sup), .lim_sig_i(lim_sig), .lim_gain_i(lim_gain),
        .state_o(state), .out_en_o(oe), .cause_o(cause)
    );

    typedef struct {
        string      tag;
        int         st;
        bit         oe;
        bit         cc;
        logic [7:0] cz;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    localparam int IDLE = 0, DIAG = 1, NORM = 2, FLT = 3, DIS = 4;

    // expectation for the state after the coming clock edge
    task automatic expect_next(string tag, int st, bit e_oe, bit cc, logic [7:0] cz);
        exp_t e;
        e.tag = tag; e.st = st; e.oe = e_oe; e.cc = cc; e.cz = cz;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic expect_run(string tag, int n, int st);
        for (int i = 0; i < n; i++)
            expect_next(tag, st, (st == DIAG || st == NORM), 1'b0, 8'h00);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (int'(state) != e.st || oe != e.oe || (e.cc && cause !== e.cz)) begin
                    fails++;
                    $display("FAIL %s state=%0d/%0d oe=%0d/%0d cause=%02h/%02h",
                             e.tag, state, e.st, oe, e.oe, cause, e.cz);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired before the sequence ended");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; start = 0; init_ok = 0; mode_5v = 0;
        sup = '0; sig = '0; crc = 0; copy = 0; pins = 3'b101;
        lim_sup = 8'd3; lim_sig = 8'd5; lim_gain = 8'd4;
        @(negedge clk);
        expect_next("R1 reset held", IDLE, 0, 1, 8'h00);
        rst = 0;
        expect_next("R1 idle after reset", IDLE, 0, 1, 8'h00);

        // R2 / R3: start, timeout, retry
        start = 1;
        expect_next("R2 idle to checking", DIAG, 1, 1, 8'h00);
        start = 0;
        expect_run("R3 checking window", 15, DIAG);
        expect_next("R3 timeout to fault", FLT, 0, 1, 8'h00);
        expect_next("R3 retry checking", DIAG, 1, 1, 8'h00);
        init_ok = 1;
        expect_next("R2 checking to normal", NORM, 1, 1, 8'h00);

        // R4 glitch filter, R7 retry
        sig[0] = 1;
        expect_run("R4 short pulse", 5, NORM);
        sig[0] = 0;
        expect_run("R4 pulse ignored", 2, NORM);
        sig[0] = 1;
        expect_run("R4 counting", 5, NORM);
        expect_next("R7 signal fault", FLT, 0, 1, 8'h80);
        expect_next("R7 retry while flag high", DIAG, 1, 1, 8'h80);
        sig[0] = 0;
        expect_next("R2 back to normal", NORM, 1, 1, 8'h80);

        // R8 output short
        sig[4] = 1;
        for (int i = 0; i < 5; i++) expect_next("R8 enable held", NORM, 1, 1, 8'h80);
        expect_next("R8 short fault", FLT, 0, 1, 8'h84);
        sig[4] = 0;
        expect_next("R7 retry", DIAG, 1, 1, 8'h84);
        expect_next("R2 normal", NORM, 1, 1, 8'h84);

        // R6 undervoltage mask, R5 wait for clear
        sup[1] = 1;
        expect_run("R6 uv ignored", 8, NORM);
        mode_5v = 1;
        expect_run("R6 uv counting", 3, NORM);
        expect_next("R5 uv fault", FLT, 0, 1, 8'h41);
        for (int i = 0; i < 5; i++) expect_next("R5 held in fault", FLT, 0, 1, 8'h41);
        sup[1] = 0;
        expect_next("R5 cleared", DIAG, 1, 1, 8'h41);
        expect_next("R5 normal", NORM, 1, 1, 8'h41);

        // R12 priority supply over signal
        lim_sig = 8'd3;
        sup[3] = 1; sig[2] = 1;
        expect_run("R12 both counting", 3, NORM);
        expect_next("R12 priority", FLT, 0, 1, 8'h43);
        sig[2] = 0;
        expect_next("R5 still waiting", FLT, 0, 1, 8'h43);
        sup[3] = 0;
        expect_next("R5 exit", DIAG, 1, 1, 8'h43);
        expect_next("R12 sticky", NORM, 1, 1, 8'h43);

        // R9 crc, R11 hold
        crc = 1;
        expect_next("R9 crc disable", DIS, 0, 1, 8'hC0);
        for (int i = 0; i < 7; i++) expect_next("R11 hold, R9 crc ignored", DIS, 0, 1, 8'hC0);
        expect_next("R11 release", DIAG, 1, 1, 8'hC0);
        crc = 0;
        expect_next("R11 normal", NORM, 1, 1, 8'hC0);

        // R9 copy
        copy = 1;
        expect_next("R9 copy disable", DIS, 0, 1, 8'hC1);
        copy = 0;
        expect_run("R11 hold", 7, DIS);
        expect_next("R11 release", DIAG, 1, 1, 8'hC1);
        expect_next("R11 normal", NORM, 1, 1, 8'hC1);

        // R10 straps
        pins = 3'b111;
        expect_next("R10 strap change", DIS, 0, 1, 8'hC3);
        expect_run("R11 hold", 7, DIS);
        expect_next("R11 release", DIAG, 1, 1, 8'hC3);
        expect_next("R10 relatched normal", NORM, 1, 1, 8'hC3);
        expect_run("R10 relatched stable", 4, NORM);
        pins = 3'b011;
        expect_run("R10 gain counting", 4, NORM);
        expect_next("R10 gain disable", DIS, 0, 1, 8'hC4);
        expect_run("R11 hold", 7, DIS);
        expect_next("R11 release", DIAG, 1, 1, 8'hC4);
        expect_next("R12 final", NORM, 1, 1, 8'hC4);

        @(posedge clk);
        #2;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule